// File: doc/BRIEF.md
# Double-Buffered Exchange Memory Between Two Processors

This block lets a bit-oriented processor (side A) and a byte-oriented processor (side B) pass data to each other through shared storage. Neither side ever waits for the other, and there is no handshake. The block has two independent channels, one for each direction. In each channel the producing side owns a working bank that it can write and read back at any time. The consuming side can only read a separate published bank, and that bank changes only when the producer issues its publish command.

A publish takes one cycle and moves no data at that moment. It swaps the roles of the two physical banks, so the contents just written become the consumer's view straight away. Over the following DEPTH cycles, a background load fills the new working bank with the published contents, one entry per cycle. The producer keeps writing and reading during the load. A read of an entry not yet loaded is answered from the published bank. A write to an entry not yet loaded is kept, and the load skips that entry. A publish that arrives while a load is still running first completes every pending entry at once, so the bank it publishes is always whole.

Both banks of each channel reset to zero. Every read port has a read enable, a one-cycle latency, and holds its data while not enabled.

Top module: `xchg_exchange_mem`

## Requirements
- R1: After reset, every read port on both sides returns 0 for every address.
- R2: Data written by a producer at an address can be read back through that producer's own read port. A read issued in the cycle after the write returns it, and the data appears one cycle after the read is issued.
- R3: A consumer read returns the contents of the producer's working bank as they were at the producer's most recent publish. Writes made after that publish are not visible to the consumer.
- R4: A consumer read issued in the same cycle as a publish returns the data from before that publish.
- R5: A write issued in the same cycle as a publish is part of the published contents.
- R6: Immediately after a publish, the producer's own read of any address returns the published value, even for entries the background load has not yet reached.
- R7: A write made after a publish, to an entry not yet loaded, is kept. It is still read back after the background load has finished.
- R8: A publish issued while a background load is still in progress publishes the complete current working contents, including entries the load had not yet reached.
- R9: The two channels are independent. A write or publish on one side never changes what the other side's producer-side read returns.
- R10: A read port's data output holds its last value while its read enable is low.
- R11: A publish swaps the working and published bank in one cycle and starts a background load that lasts exactly DEPTH cycles unless another publish interrupts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_wr_en | input | 1 | Side A write enable into its working bank |
| a_wr_addr | input | 5 | Side A write address |
| a_wr_data | input | 8 | Side A write data |
| a_own_rd_en | input | 1 | Side A read enable for its own working bank |
| a_own_rd_addr | input | 5 | Side A own read address |
| a_own_rd_data | output | 8 | Side A own read data, one-cycle latency |
| a_publish | input | 1 | Side A publish command |
| a_peer_rd_en | input | 1 | Side A read enable for data published by side B |
| a_peer_rd_addr | input | 5 | Side A peer read address |
| a_peer_rd_data | output | 8 | Data published by side B, one-cycle latency |
| b_wr_en | input | 1 | Side B write enable into its working bank |
| b_wr_addr | input | 5 | Side B write address |
| b_wr_data | input | 8 | Side B write data |
| b_own_rd_en | input | 1 | Side B read enable for its own working bank |
| b_own_rd_addr | input | 5 | Side B own read address |
| b_own_rd_data | output | 8 | Side B own read data, one-cycle latency |
| b_publish | input | 1 | Side B publish command |
| b_peer_rd_en | input | 1 | Side B read enable for data published by side A |
| b_peer_rd_addr | input | 5 | Side B peer read address |
| b_peer_rd_data | output | 8 | Data published by side A, one-cycle latency |

## Verification
The assertions check the bank bookkeeping on every cycle:
- the working/published selection flips on each publish and on nothing else;
- the published bank never changes between publishes;
- a publish always starts a load at entry zero, and the load ends after exactly DEPTH cycles;
- idle read ports hold their data.

Whether the values returned are right can only be shown by the bench's scenarios. These include a write landing in the publish cycle, a read racing a publish, writes overtaking the background load, and a second publish in the middle of a load. In each case the bench compares every read against a two-array model of the working and published contents of each channel.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;
endpackage

// File: rtl/xchg_load_seq.sv
module xchg_load_seq
  import xchg_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  output logic             sel,
  output logic [DEPTH-1:0] pending,
  output logic [DEPTH-1:0] copy_now
);
  ld_state_e        state_q, state_n;
  logic [AW-1:0]    cnt_q, cnt_n;
  logic [DEPTH-1:0] dirty_q, dirty_n;
  logic             sel_q, sel_n;

  assign sel = sel_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pending[i]  = (state_q == LD_RUN) && !dirty_q[i] && (AW'(i) >= cnt_q);
      copy_now[i] = pending[i] && ((AW'(i) == cnt_q) || upd) &&
                    !(wr_en && (wr_addr == AW'(i)));
    end
  end

  always_comb begin
    sel_n   = sel_q;
    cnt_n   = cnt_q;
    state_n = state_q;
    dirty_n = dirty_q;
    if (upd) begin
      sel_n   = ~sel_q;
      cnt_n   = '0;
      state_n = LD_RUN;
      dirty_n = '0;
    end else if (state_q == LD_RUN) begin
      cnt_n = cnt_q + AW'(1);
      if (wr_en) dirty_n[wr_addr] = 1'b1;
      if (cnt_q == AW'(DEPTH - 1)) state_n = LD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      cnt_q   <= '0;
      state_q <= LD_IDLE;
      dirty_q <= '0;
    end else begin
      sel_q   <= sel_n;
      cnt_q   <= cnt_n;
      state_q <= state_n;
      dirty_q <= dirty_n;
    end
  end

  assert_swap_on_publish_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sel_q != $past(sel_q)));
  assert_no_swap_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sel_q));
  assert_load_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (state_q == LD_RUN) && (cnt_q == '0));
  assert_load_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && state_q == LD_RUN && cnt_q == AW'(DEPTH - 1)) |=> (state_q == LD_IDLE));
endmodule

// File: rtl/xchg_bank_store.sv
module xchg_bank_store #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             sel,
  input  logic [DEPTH-1:0] pending,
  input  logic [DEPTH-1:0] copy_now,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             own_rd_en,
  input  logic [AW-1:0]    own_rd_addr,
  output logic [W-1:0]     own_rd_data,
  input  logic             peer_rd_en,
  input  logic [AW-1:0]    peer_rd_addr,
  output logic [W-1:0]     peer_rd_data
);
  logic [1:0][DEPTH-1:0][W-1:0] mem_q, mem_n;
  logic [W-1:0] own_q, own_n, peer_q, peer_n;
  logic [DEPTH-1:0][W-1:0] pub_view;

  assign pub_view = mem_q[~sel];

  always_comb begin
    mem_n = mem_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_addr == AW'(i))) mem_n[sel][i] = wr_data;
      else if (copy_now[i])             mem_n[sel][i] = mem_q[~sel][i];
    end
  end

  always_comb begin
    own_n  = own_q;
    peer_n = peer_q;
    if (own_rd_en)
      own_n = pending[own_rd_addr] ? mem_q[~sel][own_rd_addr] : mem_q[sel][own_rd_addr];
    if (peer_rd_en)
      peer_n = mem_q[~sel][peer_rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      own_q  <= '0;
      peer_q <= '0;
    end else begin
      mem_q  <= mem_n;
      own_q  <= own_n;
      peer_q <= peer_n;
    end
  end

  assign own_rd_data  = own_q;
  assign peer_rd_data = peer_q;

  assert_pub_bank_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pub_view));
  assert_peer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !peer_rd_en |=> $stable(peer_rd_data));
  assert_own_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !own_rd_en |=> $stable(own_rd_data));
endmodule

// File: rtl/xchg_channel.sv
module xchg_channel #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          own_rd_en,
  input  logic [AW-1:0] own_rd_addr,
  output logic [W-1:0]  own_rd_data,
  input  logic          peer_rd_en,
  input  logic [AW-1:0] peer_rd_addr,
  output logic [W-1:0]  peer_rd_data
);
  logic             sel;
  logic [DEPTH-1:0] pending, copy_now;

  xchg_load_seq #(.DEPTH(DEPTH)) u_seq (
    .clk, .rst_n, .upd, .wr_en, .wr_addr,
    .sel, .pending, .copy_now
  );

  xchg_bank_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk, .rst_n, .upd, .sel, .pending, .copy_now,
    .wr_en, .wr_addr, .wr_data,
    .own_rd_en, .own_rd_addr, .own_rd_data,
    .peer_rd_en, .peer_rd_addr, .peer_rd_data
  );
endmodule

// File: rtl/xchg_exchange_mem.sv
module xchg_exchange_mem #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic [AW-1:0] a_wr_addr,
  input  logic [W-1:0]  a_wr_data,
  input  logic          a_own_rd_en,
  input  logic [AW-1:0] a_own_rd_addr,
  output logic [W-1:0]  a_own_rd_data,
  input  logic          a_publish,
  input  logic          a_peer_rd_en,
  input  logic [AW-1:0] a_peer_rd_addr,
  output logic [W-1:0]  a_peer_rd_data,
  input  logic          b_wr_en,
  input  logic [AW-1:0] b_wr_addr,
  input  logic [W-1:0]  b_wr_data,
  input  logic          b_own_rd_en,
  input  logic [AW-1:0] b_own_rd_addr,
  output logic [W-1:0]  b_own_rd_data,
  input  logic          b_publish,
  input  logic          b_peer_rd_en,
  input  logic [AW-1:0] b_peer_rd_addr,
  output logic [W-1:0]  b_peer_rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Channel from side A (producer) to side B (consumer)
  xchg_channel #(.DEPTH(DEPTH), .W(W)) u_a2b (
    .clk, .rst_n(rst_int_n), .upd(a_publish),
    .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data),
    .own_rd_en(a_own_rd_en), .own_rd_addr(a_own_rd_addr), .own_rd_data(a_own_rd_data),
    .peer_rd_en(b_peer_rd_en), .peer_rd_addr(b_peer_rd_addr), .peer_rd_data(b_peer_rd_data)
  );

  // Channel from side B (producer) to side A (consumer)
  xchg_channel #(.DEPTH(DEPTH), .W(W)) u_b2a (
    .clk, .rst_n(rst_int_n), .upd(b_publish),
    .wr_en(b_wr_en), .wr_addr(b_wr_addr), .wr_data(b_wr_data),
    .own_rd_en(b_own_rd_en), .own_rd_addr(b_own_rd_addr), .own_rd_data(b_own_rd_data),
    .peer_rd_en(a_peer_rd_en), .peer_rd_addr(a_peer_rd_addr), .peer_rd_data(a_peer_rd_data)
  );
endmodule

// File: tb/xchg_exchange_mem_test.sv
module xchg_exchange_mem_test;
  localparam int DEPTH = 32;
  localparam int W     = 8;
  localparam int AW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          a_wr_en, a_own_rd_en, a_publish, a_peer_rd_en;
  logic [AW-1:0] a_wr_addr, a_own_rd_addr, a_peer_rd_addr;
  logic [W-1:0]  a_wr_data, a_own_rd_data, a_peer_rd_data;
  logic          b_wr_en, b_own_rd_en, b_publish, b_peer_rd_en;
  logic [AW-1:0] b_wr_addr, b_own_rd_addr, b_peer_rd_addr;
  logic [W-1:0]  b_wr_data, b_own_rd_data, b_peer_rd_data;

  xchg_exchange_mem uut (.*);

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [W-1:0] wa [DEPTH];
  logic [W-1:0] pa [DEPTH];
  logic [W-1:0] wb [DEPTH];
  logic [W-1:0] pb [DEPTH];
  logic [W-1:0] exp_a_own = '0, exp_a_peer = '0, exp_b_own = '0, exp_b_peer = '0;

  function automatic logic [W-1:0] rnd_byte();
    return W'($urandom % 256);
  endfunction

  task automatic check(string tag, string name, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, name, act, exp);
    end
  endtask

  task automatic idle_inputs();
    a_wr_en = 0; a_own_rd_en = 0; a_publish = 0; a_peer_rd_en = 0;
    b_wr_en = 0; b_own_rd_en = 0; b_publish = 0; b_peer_rd_en = 0;
    a_wr_addr = '0; a_own_rd_addr = '0; a_peer_rd_addr = '0; a_wr_data = '0;
    b_wr_addr = '0; b_own_rd_addr = '0; b_peer_rd_addr = '0; b_wr_data = '0;
  endtask

  // Inputs are set at a falling edge; the model takes the reads before this cycle's
  // writes and publishes, then the outputs are compared at the next falling edge.
  task automatic tick(string tag);
    if (a_own_rd_en)  exp_a_own  = wa[a_own_rd_addr];
    if (a_peer_rd_en) exp_a_peer = pb[a_peer_rd_addr];
    if (b_own_rd_en)  exp_b_own  = wb[b_own_rd_addr];
    if (b_peer_rd_en) exp_b_peer = pa[b_peer_rd_addr];
    if (a_wr_en) wa[a_wr_addr] = a_wr_data;
    if (b_wr_en) wb[b_wr_addr] = b_wr_data;
    if (a_publish) pa = wa;
    if (b_publish) pb = wb;
    @(posedge clk);
    @(negedge clk);
    check(tag, "a_own",  a_own_rd_data,  exp_a_own);
    check(tag, "a_peer", a_peer_rd_data, exp_a_peer);
    check(tag, "b_own",  b_own_rd_data,  exp_b_own);
    check(tag, "b_peer", b_peer_rd_data, exp_b_peer);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    for (int i = 0; i < DEPTH; i++) begin wa[i] = '0; pa[i] = '0; wb[i] = '0; pb[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents are zero on every port and address
    for (int i = 0; i < DEPTH; i++) begin
      a_own_rd_en = 1; a_own_rd_addr = AW'(i); a_peer_rd_en = 1; a_peer_rd_addr = AW'(i);
      b_own_rd_en = 1; b_own_rd_addr = AW'(i); b_peer_rd_en = 1; b_peer_rd_addr = AW'(i);
      tick("R1");
    end

    // R2: write then read back through the own port
    a_wr_en = 1; a_wr_addr = 5'd5; a_wr_data = 8'hA5; tick("R2");
    a_own_rd_en = 1; a_own_rd_addr = 5'd5; tick("R2");

    // R3: consumer does not see unpublished data
    b_peer_rd_en = 1; b_peer_rd_addr = 5'd5; tick("R3");
    // R4: read racing the publish gets old data
    a_publish = 1; b_peer_rd_en = 1; b_peer_rd_addr = 5'd5; tick("R4");
    b_peer_rd_en = 1; b_peer_rd_addr = 5'd5; tick("R3");

    // R6: own read of a not-yet-loaded entry right after publish
    a_wr_en = 1; a_wr_addr = 5'd30; a_wr_data = 8'h3C; tick("R6");
    a_publish = 1; tick("R6");
    a_own_rd_en = 1; a_own_rd_addr = 5'd30; tick("R6");
    a_own_rd_en = 1; a_own_rd_addr = 5'd5; tick("R6");

    // R7: write to an unloaded entry survives the load; consumer keeps old view
    a_wr_en = 1; a_wr_addr = 5'd28; a_wr_data = 8'h77; tick("R7");
    repeat (DEPTH + 4) tick("R7");
    a_own_rd_en = 1; a_own_rd_addr = 5'd28; b_peer_rd_en = 1; b_peer_rd_addr = 5'd28; tick("R7");

    // R5: write in the publish cycle is published
    a_wr_en = 1; a_wr_addr = 5'd9; a_wr_data = 8'h5A; a_publish = 1; tick("R5");
    b_peer_rd_en = 1; b_peer_rd_addr = 5'd9; tick("R5");

    // R8: second publish in the middle of a load
    a_wr_en = 1; a_wr_addr = 5'd3; a_wr_data = 8'h11; tick("R8");
    a_publish = 1; tick("R8");
    a_wr_en = 1; a_wr_addr = 5'd3; a_wr_data = 8'h22; tick("R8");
    a_publish = 1; tick("R8");
    for (int i = 0; i < DEPTH; i++) begin
      b_peer_rd_en = 1; b_peer_rd_addr = AW'(i); a_own_rd_en = 1; a_own_rd_addr = AW'(i);
      tick("R8");
    end

    // R9: side B traffic leaves side A's own view and B's peer view unchanged
    b_wr_en = 1; b_wr_addr = 5'd9; b_wr_data = 8'hEE; b_publish = 1; tick("R9");
    a_own_rd_en = 1; a_own_rd_addr = 5'd9; b_peer_rd_en = 1; b_peer_rd_addr = 5'd9;
    a_peer_rd_en = 1; a_peer_rd_addr = 5'd9; tick("R9");

    // R10: outputs hold while enables are low
    repeat (3) tick("R10");

    // R11: back-to-back and spaced publishes under random traffic
    for (int n = 0; n < 4000; n++) begin
      a_wr_en = 1'($urandom % 2); a_wr_addr = AW'($urandom); a_wr_data = rnd_byte();
      b_wr_en = 1'($urandom % 2); b_wr_addr = AW'($urandom); b_wr_data = rnd_byte();
      a_publish = ($urandom % 16) == 0; b_publish = ($urandom % 24) == 0;
      a_own_rd_en = 1'($urandom % 2); a_own_rd_addr = AW'($urandom);
      b_own_rd_en = 1'($urandom % 2); b_own_rd_addr = AW'($urandom);
      a_peer_rd_en = 1'($urandom % 2); a_peer_rd_addr = AW'($urandom);
      b_peer_rd_en = 1'($urandom % 2); b_peer_rd_addr = AW'($urandom);
      tick("R11");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule